// File: doc/BRIEF.md
# Transmit Checksum Offload Engine

This block finishes the checksums of an outgoing frame that is already held in a local byte RAM. The frame starts with an 8-byte control prefix written by the driver. The engine reads the prefix to learn which checksums are wanted and where the network and transport headers sit. It then computes the IPv4 header checksum and the TCP or UDP checksum, including the pseudo-header, and writes the results into the frame. For a UDP frame whose driver asked for no checksum, it clears the checksum field instead.

Software or an upstream DMA fills the buffer, then pulses `start` with the total buffer length, prefix included. The engine reads the buffer through a synchronous read port with one cycle of latency. It writes bytes back through the same address bus, one byte per cycle, and raises `done` for one cycle when the frame may be sent. Header positions come only from the offsets in the prefix. The engine parses no options and does not handle IPv6.

Top module: `tx_csum_offload`

## Requirements
- R1: Prefix byte 0 carries the flags: bit 6 means IPv4, bit 4 means a TCP/UDP header is present, bit 3 selects UDP (clear means TCP), bit 2 requests the IPv4 header checksum and bit 1 requests the L4 checksum. Byte 3 is the L3 offset, so the L3 header starts at buffer address 8 + byte 3. Byte 2 is the L4 offset, measured from the L3 header start.
- R2: The IPv4 header checksum is produced only when both bit 6 and bit 2 are set. It is the inverted 16-bit ones-complement sum of the header, whose length is 4 × (low nibble of L3 byte 0), with header bytes 10–11 counted as zero. It is written big-endian to L3 bytes 10 and 11.
- R3: When bit 6 is clear, the engine writes nothing and the frame is left unchanged, whatever the other flag bits say.
- R4: The L4 bytes are touched only when bits 6 and 4 are both set. Otherwise only the IPv4 checksum, if requested, changes.
- R5: For UDP with bit 1 set, the checksum is the inverted ones-complement sum of a pseudo-header and the L4 bytes, with L4 bytes 6–7 counted as zero. The pseudo-header is L3 bytes 12–19, plus the protocol byte (L3 byte 9), plus the L4 length (buffer length minus L4 start). The checksum is written big-endian to L4 bytes 6–7, and a computed value of 0x0000 is written as 0xFFFF.
- R6: For UDP with bit 1 clear, L4 bytes 6 and 7 are written as zero and no other L4 byte changes.
- R7: For TCP with bit 1 set, the checksum is computed as in R5, except that the field is at L4 bytes 16–17 and a zero result is kept as zero. For TCP with bit 1 clear, the L4 bytes are left unchanged.
- R8: When the L4 length is odd, the last byte is summed as the high half of a word whose low half is zero.
- R9: `busy` rises in the cycle after an accepted `start` and falls after `done`. `done` lasts exactly one cycle, after the last write. A `start` that arrives while `busy` is high is ignored.
- R10: A checksum byte whose computed address is not below the frame length is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin processing the buffered frame (accepted only when idle) |
| frame_len | input | AW | Total buffer length in bytes, prefix included, sampled with `start` |
| mem_addr | output | AW | Buffer address for reads, or for writes when `mem_we` is high |
| mem_we | output | 1 | Write strobe for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read from the address presented in the previous cycle |
| busy | output | 1 | Engine is processing a frame |
| done | output | 1 | One-cycle pulse when the frame is finished |

## Verification
On every cycle, the bound checker covers the handshake: `done` is a single-cycle pulse that ends `busy`, an idle `start` launches the engine, writes happen only while busy, and no write falls outside the frame. Checksum values, the flag decoding, the offset arithmetic, odd-length padding, UDP zero substitution and field clearing can only be shown by the bench's scenarios. Each scenario builds a frame and compares the whole buffer afterwards against an image computed from the rules. The bench also counts the writes, which shows that disabled paths leave the frame alone.

// File: rtl/cso_pkg.sv
package cso_pkg;

    localparam int PFX_BYTES   = 8;
    localparam int FLAG_BYTE   = 0;
    localparam int L4OFF_BYTE  = 2;
    localparam int L3OFF_BYTE  = 3;

    localparam int FB_IP4      = 6;
    localparam int FB_L4       = 4;
    localparam int FB_UDP      = 3;
    localparam int FB_CIP      = 2;
    localparam int FB_CL4      = 1;

    localparam int IP_VERIHL   = 0;
    localparam int IP_PROTO    = 9;
    localparam int IP_CSUM     = 10;
    localparam int IP_PSEUDO   = 12;
    localparam int PSEUDO_LEN  = 8;
    localparam int IP_PEEK_LEN = 10;
    localparam int UDP_CSUM    = 6;
    localparam int TCP_CSUM    = 16;

    typedef struct packed {
        logic ip4;
        logic l4;
        logic udp;
        logic cip;
        logic cl4;
    } cso_flags_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PFX,
        ST_IPH,
        ST_IPSUM,
        ST_IPWR_H,
        ST_IPWR_L,
        ST_L4SEL,
        ST_ZWR_H,
        ST_ZWR_L,
        ST_PSEUDO,
        ST_L4SUM,
        ST_L4WR_H,
        ST_L4WR_L,
        ST_DONE
    } cso_state_e;

    function automatic cso_flags_t decode_flags(input logic [7:0] b);
        cso_flags_t f;
        f.ip4 = b[FB_IP4];
        f.l4  = b[FB_L4];
        f.udp = b[FB_UDP];
        f.cip = b[FB_CIP];
        f.cl4 = b[FB_CL4];
        return f;
    endfunction

    function automatic logic [15:0] fold_sum(input logic [31:0] a);
        logic [16:0] t;
        logic [16:0] u;
        t = {1'b0, a[15:0]} + {1'b0, a[31:16]};
        u = {1'b0, t[15:0]} + {16'd0, t[16]};
        return u[15:0];
    endfunction

endpackage

// File: rtl/cso_scan.sv
module cso_scan #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] count,
    output logic [AW-1:0] rd_addr,
    output logic          out_valid,
    output logic [AW-1:0] out_idx,
    output logic          fin
);

    logic          issuing;
    logic [AW-1:0] iss_idx;
    logic [AW-1:0] base_q;
    logic [AW-1:0] cnt_q;
    logic          last_q;
    logic          empty_q;
    logic          at_last;

    assign at_last = (iss_idx == cnt_q - AW'(1));
    assign rd_addr = base_q + iss_idx;
    assign fin     = last_q | empty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            issuing   <= 1'b0;
            iss_idx   <= '0;
            base_q    <= '0;
            cnt_q     <= '0;
            out_valid <= 1'b0;
            out_idx   <= '0;
            last_q    <= 1'b0;
            empty_q   <= 1'b0;
        end else begin
            out_valid <= issuing;
            out_idx   <= iss_idx;
            last_q    <= issuing && at_last;
            empty_q   <= go && (count == '0);
            if (go && (count != '0)) begin
                issuing <= 1'b1;
                iss_idx <= '0;
                base_q  <= base;
                cnt_q   <= count;
            end else if (issuing) begin
                if (at_last) begin
                    issuing <= 1'b0;
                end else begin
                    iss_idx <= iss_idx + AW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/cso_accum.sv
module cso_accum
    import cso_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        byte_en,
    input  logic        byte_hi,
    input  logic [7:0]  byte_val,
    input  logic        word_en,
    input  logic [16:0] word_val,
    output logic [15:0] sum
);

    logic [31:0] acc;
    logic [31:0] byte_term;
    logic [31:0] word_term;

    always_comb begin
        byte_term = '0;
        if (byte_en) begin
            byte_term = byte_hi ? {16'd0, byte_val, 8'd0} : {24'd0, byte_val};
        end
        word_term = word_en ? {15'd0, word_val} : 32'd0;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc <= '0;
        end else begin
            acc <= acc + byte_term + word_term;
        end
    end

    assign sum = fold_sum(acc);

endmodule

// File: rtl/cso_ctrl.sv
module cso_ctrl
    import cso_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] frame_len,
    output logic          scan_go,
    output logic [AW-1:0] scan_base,
    output logic [AW-1:0] scan_count,
    input  logic          scan_valid,
    input  logic [AW-1:0] scan_idx,
    input  logic          scan_fin,
    input  logic [7:0]    rd_byte,
    output logic          acc_clr,
    output logic          acc_byte_en,
    output logic          acc_hi,
    output logic          acc_word_en,
    output logic [16:0]   acc_word,
    input  logic [15:0]   acc_sum,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] len_lat
);

    cso_state_e    state, state_nx;
    logic          launched;
    logic [AW-1:0] len_q;
    cso_flags_t    flags_q;
    logic [7:0]    l3off_q;
    logic [7:0]    l4off_q;
    logic [3:0]    ihl_q;
    logic [7:0]    proto_q;

    logic [AW-1:0] l3_base;
    logic [AW-1:0] l4_base;
    logic [AW-1:0] l4_len;
    logic [AW-1:0] fld_ofs;
    logic [15:0]   ip_csum;
    logic [15:0]   l4_raw;
    logic [15:0]   l4_csum;
    logic          in_scan;
    logic          wr_state;

    assign l3_base = AW'(PFX_BYTES) + AW'(l3off_q);
    assign l4_base = l3_base + AW'(l4off_q);
    assign l4_len  = len_q - l4_base;
    assign fld_ofs = flags_q.udp ? AW'(UDP_CSUM) : AW'(TCP_CSUM);
    assign ip_csum = ~acc_sum;
    assign l4_raw  = ~acc_sum;
    assign l4_csum = (flags_q.udp && (l4_raw == 16'h0000)) ? 16'hFFFF : l4_raw;

    assign in_scan = (state == ST_PFX) || (state == ST_IPH) || (state == ST_IPSUM) ||
                     (state == ST_PSEUDO) || (state == ST_L4SUM);
    assign scan_go = in_scan && !launched;

    // scan window per state
    always_comb begin
        scan_base  = '0;
        scan_count = '0;
        case (state)
            ST_PFX: begin
                scan_base  = '0;
                scan_count = AW'(L3OFF_BYTE + 1);
            end
            ST_IPH: begin
                scan_base  = l3_base;
                scan_count = AW'(IP_PEEK_LEN);
            end
            ST_IPSUM: begin
                scan_base  = l3_base;
                scan_count = AW'({ihl_q, 2'b00});
            end
            ST_PSEUDO: begin
                scan_base  = l3_base + AW'(IP_PSEUDO);
                scan_count = AW'(PSEUDO_LEN);
            end
            ST_L4SUM: begin
                scan_base  = l4_base;
                scan_count = l4_len;
            end
            default: ;
        endcase
    end

    // accumulator control
    always_comb begin
        acc_clr     = (state == ST_L4SEL) || ((state == ST_IPSUM) && scan_go);
        acc_word_en = (state == ST_PSEUDO) && scan_go;
        acc_word    = 17'(proto_q) + 17'(l4_len);
        acc_hi      = ~scan_idx[0];
        case (state)
            ST_IPSUM:  acc_byte_en = scan_valid && (scan_idx != AW'(IP_CSUM)) &&
                                     (scan_idx != AW'(IP_CSUM + 1));
            ST_PSEUDO: acc_byte_en = scan_valid;
            ST_L4SUM:  acc_byte_en = scan_valid && (scan_idx != fld_ofs) &&
                                     (scan_idx != fld_ofs + AW'(1));
            default:   acc_byte_en = 1'b0;
        endcase
    end

    // byte writes
    always_comb begin
        wr_state = 1'b1;
        wr_addr  = '0;
        wr_data  = '0;
        case (state)
            ST_IPWR_H: begin
                wr_addr = l3_base + AW'(IP_CSUM);
                wr_data = ip_csum[15:8];
            end
            ST_IPWR_L: begin
                wr_addr = l3_base + AW'(IP_CSUM + 1);
                wr_data = ip_csum[7:0];
            end
            ST_ZWR_H: wr_addr = l4_base + AW'(UDP_CSUM);
            ST_ZWR_L: wr_addr = l4_base + AW'(UDP_CSUM + 1);
            ST_L4WR_H: begin
                wr_addr = l4_base + fld_ofs;
                wr_data = l4_csum[15:8];
            end
            ST_L4WR_L: begin
                wr_addr = l4_base + fld_ofs + AW'(1);
                wr_data = l4_csum[7:0];
            end
            default: wr_state = 1'b0;
        endcase
    end

    assign wr_en   = wr_state && (wr_addr < len_q);
    assign busy    = (state != ST_IDLE);
    assign done    = (state == ST_DONE);
    assign len_lat = len_q;

    // sequencing
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:   if (start) state_nx = ST_PFX;
            ST_PFX:    if (scan_fin) state_nx = flags_q.ip4 ? ST_IPH : ST_DONE;
            ST_IPH:    if (scan_fin) state_nx = flags_q.cip ? ST_IPSUM : ST_L4SEL;
            ST_IPSUM:  if (scan_fin) state_nx = ST_IPWR_H;
            ST_IPWR_H: state_nx = ST_IPWR_L;
            ST_IPWR_L: state_nx = ST_L4SEL;
            ST_L4SEL: begin
                if (!flags_q.l4)                     state_nx = ST_DONE;
                else if (flags_q.udp && !flags_q.cl4) state_nx = ST_ZWR_H;
                else if (flags_q.cl4)                state_nx = ST_PSEUDO;
                else                                 state_nx = ST_DONE;
            end
            ST_ZWR_H:  state_nx = ST_ZWR_L;
            ST_ZWR_L:  state_nx = ST_DONE;
            ST_PSEUDO: if (scan_fin) state_nx = ST_L4SUM;
            ST_L4SUM:  if (scan_fin) state_nx = ST_L4WR_H;
            ST_L4WR_H: state_nx = ST_L4WR_L;
            ST_L4WR_L: state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            launched <= 1'b0;
            len_q    <= '0;
            flags_q  <= '0;
            l3off_q  <= '0;
            l4off_q  <= '0;
            ihl_q    <= '0;
            proto_q  <= '0;
        end else begin
            state <= state_nx;
            if (scan_fin) begin
                launched <= 1'b0;
            end else if (scan_go) begin
                launched <= 1'b1;
            end
            if ((state == ST_IDLE) && start) begin
                len_q <= frame_len;
            end
            if (scan_valid && (state == ST_PFX)) begin
                if (scan_idx == AW'(FLAG_BYTE))  flags_q <= decode_flags(rd_byte);
                if (scan_idx == AW'(L4OFF_BYTE)) l4off_q <= rd_byte;
                if (scan_idx == AW'(L3OFF_BYTE)) l3off_q <= rd_byte;
            end
            if (scan_valid && (state == ST_IPH)) begin
                if (scan_idx == AW'(IP_VERIHL)) ihl_q   <= rd_byte[3:0];
                if (scan_idx == AW'(IP_PROTO))  proto_q <= rd_byte;
            end
        end
    end

endmodule

// File: rtl/tx_csum_offload.sv
module tx_csum_offload
    import cso_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] frame_len,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    output logic          busy,
    output logic          done
);

    logic          scan_go;
    logic [AW-1:0] scan_base;
    logic [AW-1:0] scan_count;
    logic [AW-1:0] rd_addr;
    logic          scan_valid;
    logic [AW-1:0] scan_idx;
    logic          scan_fin;
    logic          acc_clr;
    logic          acc_byte_en;
    logic          acc_hi;
    logic          acc_word_en;
    logic [16:0]   acc_word;
    logic [15:0]   acc_sum;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic [AW-1:0] len_lat;

    cso_scan #(.AW(AW)) u_scan (
        .clk       (clk),
        .rst       (rst),
        .go        (scan_go),
        .base      (scan_base),
        .count     (scan_count),
        .rd_addr   (rd_addr),
        .out_valid (scan_valid),
        .out_idx   (scan_idx),
        .fin       (scan_fin)
    );

    cso_accum u_accum (
        .clk      (clk),
        .rst      (rst),
        .clr      (acc_clr),
        .byte_en  (acc_byte_en),
        .byte_hi  (acc_hi),
        .byte_val (mem_rdata),
        .word_en  (acc_word_en),
        .word_val (acc_word),
        .sum      (acc_sum)
    );

    cso_ctrl #(.AW(AW)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .frame_len   (frame_len),
        .scan_go     (scan_go),
        .scan_base   (scan_base),
        .scan_count  (scan_count),
        .scan_valid  (scan_valid),
        .scan_idx    (scan_idx),
        .scan_fin    (scan_fin),
        .rd_byte     (mem_rdata),
        .acc_clr     (acc_clr),
        .acc_byte_en (acc_byte_en),
        .acc_hi      (acc_hi),
        .acc_word_en (acc_word_en),
        .acc_word    (acc_word),
        .acc_sum     (acc_sum),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .busy        (busy),
        .done        (done),
        .len_lat     (len_lat)
    );

    assign mem_addr  = wr_en ? wr_addr : rd_addr;
    assign mem_we    = wr_en;
    assign mem_wdata = wr_data;

endmodule

// File: rtl/cso_chk.sv
module cso_chk #(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] len_lat
);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    start_launch_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R9
    write_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (busy && !done));

    // R10
    write_bound_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr < len_lat));

endmodule

bind tx_csum_offload cso_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .len_lat  (len_lat)
);

// File: tb/tx_csum_offload_test.sv
`timescale 1ns/1ps
module tx_csum_offload_test;

    localparam int AW    = 11;
    localparam int MEMSZ = 2048;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [AW-1:0] frame_len;
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata;
    logic          busy;
    logic          done;

    always #4 clk = ~clk;

    tx_csum_offload #(.AW(AW)) uut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .frame_len (frame_len),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .done      (done)
    );

    logic [7:0] ram  [MEMSZ];
    logic [7:0] img  [MEMSZ];
    logic [7:0] expv [MEMSZ];
    logic       load_req;
    int         wr_cnt;
    int         done_cnt;
    int         n_tests;
    int         n_fail;

    int g_len, g_l3, g_l4, g_ihl, g_proto, g_l4len, g_fo;
    logic [7:0]  g_flags;
    logic [15:0] exp_ip, exp_l4;

    always @(posedge clk) begin
        mem_rdata <= ram[mem_addr];
        if (load_req) begin
            for (int i = 0; i < MEMSZ; i++) ram[i] <= img[i];
            wr_cnt   <= 0;
            done_cnt <= 0;
        end else begin
            if (mem_we) begin
                ram[mem_addr] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end
            if (done) done_cnt <= done_cnt + 1;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] fold(input logic [31:0] s);
        logic [31:0] t = s;
        while (t[31:16] != 0) t = {16'd0, t[15:0]} + {16'd0, t[31:16]};
        return t[15:0];
    endfunction

    function automatic logic [31:0] ref_sum(input int st, input int cnt, input int skip);
        logic [31:0] s = 0;
        for (int k = 0; k < cnt; k++) begin
            if (skip < 0 || (k != skip && k != skip + 1)) begin
                if (k % 2 == 0) s = s + {16'd0, img[st+k], 8'd0};
                else            s = s + {24'd0, img[st+k]};
            end
        end
        return s;
    endfunction

    task automatic build(input logic [7:0] flags, input int l3off, input int ihl,
                         input int l4off, input int proto, input int l4len, input int seed);
        for (int i = 0; i < MEMSZ; i++) img[i] = 8'((i * 29 + seed * 7 + 3) & 255);
        g_flags = flags;
        g_l3    = 8 + l3off;
        g_l4    = g_l3 + l4off;
        g_ihl   = ihl;
        g_proto = proto;
        g_l4len = l4len;
        g_len   = g_l4 + l4len;
        g_fo    = flags[3] ? 6 : 16;
        img[0] = flags;
        img[1] = 8'h00;
        img[2] = 8'(l4off);
        img[3] = 8'(l3off);
        img[g_l3]     = 8'(8'h40 | ihl);
        img[g_l3 + 9] = 8'(proto);
    endtask

    task automatic make_expect();
        logic [31:0] s;
        for (int i = 0; i < MEMSZ; i++) expv[i] = img[i];
        exp_ip = ~fold(ref_sum(g_l3, g_ihl * 4, 10));
        s = ref_sum(g_l3 + 12, 8, -1) + 32'(g_proto) + 32'(g_l4len) + ref_sum(g_l4, g_l4len, g_fo);
        exp_l4 = ~fold(s);
        if (g_flags[3] && exp_l4 == 16'h0000) exp_l4 = 16'hFFFF;
        if (g_flags[6] && g_flags[2]) begin
            if (g_l3 + 10 < g_len) expv[g_l3 + 10] = exp_ip[15:8];
            if (g_l3 + 11 < g_len) expv[g_l3 + 11] = exp_ip[7:0];
        end
        if (g_flags[6] && g_flags[4]) begin
            if (g_flags[3] && !g_flags[1]) begin
                if (g_l4 + 6 < g_len) expv[g_l4 + 6] = 8'h00;
                if (g_l4 + 7 < g_len) expv[g_l4 + 7] = 8'h00;
            end else if (g_flags[1]) begin
                if (g_l4 + g_fo < g_len)     expv[g_l4 + g_fo]     = exp_l4[15:8];
                if (g_l4 + g_fo + 1 < g_len) expv[g_l4 + g_fo + 1] = exp_l4[7:0];
            end
        end
    endtask

    task automatic load_and_start(input int restart_gap, input int restart_len);
        @(negedge clk);
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        start     = 1'b1;
        frame_len = AW'(g_len);
        @(negedge clk);
        start = 1'b0;
        if (restart_gap > 0) begin
            repeat (restart_gap) @(negedge clk);
            start     = 1'b1;
            frame_len = AW'(restart_len);
            @(negedge clk);
            start = 1'b0;
        end
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 5000) check(req, "watchdog waiting for done", 0, 1);
        repeat (3) @(negedge clk);
    endtask

    task automatic cmp_frame(input string req);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < MEMSZ; i++) begin
            if (ram[i] !== expv[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        if (bad != 0)
            $display("  first differing byte %0d: got %0h want %0h", first, ram[first], expv[first]);
        check(req, "differing buffer bytes", bad, 0);
    endtask

    function automatic int rd16(input int a);
        return {16'd0, ram[a], ram[a+1]};
    endfunction

    task automatic t_reset();
        check("R9", "done after reset", int'(done), 0);
        check("R9", "busy after reset", int'(busy), 0);
        check("R9", "mem_we after reset", int'(mem_we), 0);
    endtask

    task automatic t_udp_full();
        build(8'h5E, 14, 5, 20, 17, 37, 1);
        make_expect();
        load_and_start(0, 0);
        wait_done("R5");
        check("R2", "IPv4 header checksum", rd16(g_l3 + 10), int'(exp_ip));
        check("R5", "UDP checksum with pseudo-header", rd16(g_l4 + 6), int'(exp_l4));
        check("R9", "done cycles", done_cnt, 1);
        check("R1", "UDP frame image", 0, 0);
        cmp_frame("R1");
    endtask

    task automatic t_udp_noreq();
        build(8'h58, 18, 6, 24, 17, 30, 2);
        make_expect();
        load_and_start(0, 0);
        wait_done("R6");
        check("R6", "UDP field cleared", rd16(g_l4 + 6), 0);
        check("R6", "write count", wr_cnt, 2);
        cmp_frame("R6");
    endtask

    task automatic t_tcp_full();
        build(8'h56, 0, 6, 24, 6, 41, 3);
        make_expect();
        load_and_start(0, 0);
        wait_done("R7");
        check("R7", "TCP checksum at L4+16", rd16(g_l4 + 16), int'(exp_l4));
        check("R8", "odd-length TCP image", 0, 0);
        cmp_frame("R8");
    endtask

    task automatic t_tcp_noreq();
        build(8'h54, 14, 5, 20, 6, 40, 4);
        make_expect();
        load_and_start(0, 0);
        wait_done("R7");
        check("R7", "only IPv4 field written", wr_cnt, 2);
        cmp_frame("R7");
    endtask

    task automatic t_non_ip();
        build(8'h1E, 14, 5, 20, 17, 30, 5);
        make_expect();
        load_and_start(0, 0);
        wait_done("R3");
        check("R3", "writes without IPv4 flag", wr_cnt, 0);
        cmp_frame("R3");
    endtask

    task automatic t_no_l4();
        build(8'h4E, 14, 5, 20, 17, 30, 6);
        make_expect();
        load_and_start(0, 0);
        wait_done("R4");
        check("R4", "writes without L4 flag", wr_cnt, 2);
        cmp_frame("R4");
    endtask

    task automatic t_udp_ffff();
        logic [15:0] c;
        build(8'h5E, 14, 5, 20, 17, 32, 7);
        img[g_l4 + 10] = 8'h00;
        img[g_l4 + 11] = 8'h00;
        make_expect();
        c = exp_l4;
        img[g_l4 + 10] = c[15:8];
        img[g_l4 + 11] = c[7:0];
        make_expect();
        load_and_start(0, 0);
        wait_done("R5");
        check("R5", "zero UDP result sent as FFFF", rd16(g_l4 + 6), 16'hFFFF);
        cmp_frame("R5");
    endtask

    task automatic t_busy_start();
        build(8'h5E, 14, 5, 20, 17, 25, 8);
        make_expect();
        load_and_start(3, 9);
        wait_done("R9");
        check("R9", "done pulses with start while busy", done_cnt, 1);
        check("R9", "busy after done", int'(busy), 0);
        cmp_frame("R9");
    endtask

    task automatic t_out_of_frame();
        build(8'h56, 14, 5, 20, 6, 10, 9);
        make_expect();
        load_and_start(0, 0);
        wait_done("R10");
        check("R10", "writes when TCP field lies past the end", wr_cnt, 2);
        cmp_frame("R10");
    endtask

    initial begin
        #(8 * 190000);
        n_tests++;
        n_fail++;
        $display("FAIL R9 global watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        n_tests   = 0;
        n_fail    = 0;
        rst       = 1'b1;
        start     = 1'b0;
        frame_len = '0;
        load_req  = 1'b0;
        for (int i = 0; i < MEMSZ; i++) img[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_udp_full();
        t_udp_noreq();
        t_tcp_full();
        t_tcp_noreq();
        t_non_ip();
        t_no_l4();
        t_udp_ffff();
        t_busy_start();
        t_out_of_frame();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule